// File: doc/BRIEF.md
# Lock-Step Two-Slot Bundle Issue Stage

This block is the issue and execute stage of a statically scheduled processor that runs two-operation bundles. The compiler has already grouped the operations and placed each one in its slot. Slot 0 always goes to a single-cycle arithmetic unit. Slot 1 always goes to a unit whose latency is programmable from one to four cycles. The hardware never checks for dependencies between the two slots and never reroutes an operation to a different unit. Each slot simply reads the operands it was given.

The stage accepts one bundle per cycle through a valid/ready handshake. Execution is all-or-none. While slot 1 is still busy, the whole bundle waits. Slot 0's finished result is held back, and no new bundle is accepted. Both results come out together in a single result-valid cycle. Three counters are kept: bundles retired, cycles spent stalled, and slots issued. Empty slots count as issued. The bench uses these counters to check cycle counts against its own model.

Top module: `vliw_lockstep_issue`

## Requirements
- R1: After a synchronous active-high reset, `bundle_ready` is 1, `res_valid` is 0, and all three counters read 0.
- R2: The opcode of each slot is bits [3:0] of its 32-bit word. The encodings are: 0 NOP (result 0), 1 add, 2 subtract (a-b), 3 AND, 4 OR, 5 XOR, and 6 add-immediate (a plus bits [31:4] zero-extended). Opcodes 7 to 15 give 0.
- R3: Neither slot sees the other's operands or result. Each result depends only on its own slot word and its own a/b operands from the same bundle.
- R4: If slot 1 holds a NOP or `lat_cfg` is 0, the bundle retires at the clock edge that accepts it. Its results show with `res_valid` in the following cycle, and `bundle_ready` stays 1. Back-to-back bundles therefore retire one per cycle with no stall cycles.
- R5: A non-NOP slot 1 accepted with `lat_cfg`=c>0 holds `bundle_ready` low for the c cycles after acceptance. Its results show c+1 cycles after the accepting edge.
- R6: During a stall, the slot 0 result is delivered only together with slot 1's result, in one `res_valid` cycle. Input changes while `bundle_ready` is low have no effect.
- R7: A NOP in slot 1 finishes at once, whatever `lat_cfg` says. `issued_ops` rises by 2 for every accepted bundle, NOP slots included.
- R8: `stall_cnt` rises by one for every cycle a bundle waits on slot 1, so by c for each multi-cycle bundle.
- R9: Reset in the middle of a stalled bundle drops that bundle. No result appears, `retired_cnt` stays 0, and `bundle_ready` returns to 1.
- R10: `lat_cfg` is sampled when the bundle is accepted. Changes to it during the stall do not alter that bundle's latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bundle_valid | input | 1 | A bundle is offered |
| bundle_ready | output | 1 | Stage can accept a bundle this cycle |
| slot0_op | input | 32 | Slot 0 operation word |
| slot1_op | input | 32 | Slot 1 operation word |
| slot0_a | input | 32 | Slot 0 first operand |
| slot0_b | input | 32 | Slot 0 second operand |
| slot1_a | input | 32 | Slot 1 first operand |
| slot1_b | input | 32 | Slot 1 second operand |
| lat_cfg | input | 2 | Slot 1 unit latency minus one |
| res_valid | output | 1 | Results of a retired bundle are valid |
| res0 | output | 32 | Slot 0 result |
| res1 | output | 32 | Slot 1 result |
| retired_cnt | output | 16 | Bundles retired |
| stall_cnt | output | 16 | Cycles stalled on slot 1 |
| issued_ops | output | 16 | Slots issued, NOPs included |

## Verification
The bench measures the length of the ready-low window and the cycle in which the result appears, at every latency setting. A design that is off by one cycle in its countdown, or that lets slot 0 retire ahead of slot 1, would show results in the wrong cycle or fail the stall count. During stalls the bench changes the offered data and `lat_cfg`. A stage that took a new bundle early, or that re-read its latency, would either return the new bundle's data or finish at a different time. The bench also puts a NOP in slot 1 while a long latency is selected, and asserts reset partway through a stall. A design that charged NOPs the unit latency, or that let a dropped bundle retire anyway, would be caught there.

// File: rtl/vliw_lockstep_issue.sv
module vliw_lockstep_issue #(
  parameter int DATA_W = 32,
  parameter int OPC_W  = 4,
  parameter int LAT_W  = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bundle_valid,
  output logic              bundle_ready,
  input  logic [DATA_W-1:0] slot0_op,
  input  logic [DATA_W-1:0] slot1_op,
  input  logic [DATA_W-1:0] slot0_a,
  input  logic [DATA_W-1:0] slot0_b,
  input  logic [DATA_W-1:0] slot1_a,
  input  logic [DATA_W-1:0] slot1_b,
  input  logic [LAT_W-1:0]  lat_cfg,
  output logic              res_valid,
  output logic [DATA_W-1:0] res0,
  output logic [DATA_W-1:0] res1,
  output logic [CNT_W-1:0]  retired_cnt,
  output logic [CNT_W-1:0]  stall_cnt,
  output logic [CNT_W-1:0]  issued_ops
);

  localparam int IMM_W = DATA_W - OPC_W;
  localparam logic [OPC_W-1:0] OP_NOP = '0;

  function automatic logic [DATA_W-1:0] fu_calc(
    input logic [DATA_W-1:0] word,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b
  );
    logic [DATA_W-1:0] imm;
    imm = {{OPC_W{1'b0}}, word[DATA_W-1:OPC_W]};
    case (word[OPC_W-1:0])
      OPC_W'(1): fu_calc = a + b;
      OPC_W'(2): fu_calc = a - b;
      OPC_W'(3): fu_calc = a & b;
      OPC_W'(4): fu_calc = a | b;
      OPC_W'(5): fu_calc = a ^ b;
      OPC_W'(6): fu_calc = a + imm;
      default:   fu_calc = '0;
    endcase
  endfunction

  logic              busy;
  logic [LAT_W-1:0]  wait_q;
  logic [DATA_W-1:0] h_op0, h_op1, h_a0, h_b0, h_a1, h_b1;

  logic accept, long_op, done1, retire;
  logic [DATA_W-1:0] s_op0, s_op1, s_a0, s_b0, s_a1, s_b1;

  assign bundle_ready = !busy;
  assign accept  = bundle_valid && bundle_ready;
  assign long_op = (slot1_op[OPC_W-1:0] != OP_NOP) && (lat_cfg != '0);
  assign done1   = busy && (wait_q == LAT_W'(1));
  assign retire  = (accept && !long_op) || done1;

  assign s_op0 = busy ? h_op0 : slot0_op;
  assign s_op1 = busy ? h_op1 : slot1_op;
  assign s_a0  = busy ? h_a0  : slot0_a;
  assign s_b0  = busy ? h_b0  : slot0_b;
  assign s_a1  = busy ? h_a1  : slot1_a;
  assign s_b1  = busy ? h_b1  : slot1_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      wait_q      <= '0;
      res_valid   <= 1'b0;
      res0        <= '0;
      res1        <= '0;
      retired_cnt <= '0;
      stall_cnt   <= '0;
      issued_ops  <= '0;
      h_op0 <= '0; h_op1 <= '0;
      h_a0  <= '0; h_b0  <= '0;
      h_a1  <= '0; h_b1  <= '0;
    end else begin
      res_valid <= retire;
      if (retire) begin
        res0        <= fu_calc(s_op0, s_a0, s_b0);
        res1        <= fu_calc(s_op1, s_a1, s_b1);
        retired_cnt <= retired_cnt + CNT_W'(1);
      end
      if (accept) begin
        issued_ops <= issued_ops + CNT_W'(2);
        h_op0 <= slot0_op; h_op1 <= slot1_op;
        h_a0  <= slot0_a;  h_b0  <= slot0_b;
        h_a1  <= slot1_a;  h_b1  <= slot1_b;
        if (long_op) begin
          busy   <= 1'b1;
          wait_q <= lat_cfg;
        end
      end
      if (busy) begin
        stall_cnt <= stall_cnt + CNT_W'(1);
        if (done1) busy <= 1'b0;
        else       wait_q <= wait_q - LAT_W'(1);
      end
    end
  end

  assert_short_retires_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && !long_op) |=> (res_valid && bundle_ready &&
                              retired_cnt == $past(retired_cnt) + CNT_W'(1)));

  assert_long_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && long_op) |=> (!bundle_ready && !res_valid));

  assert_hold_until_done_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !done1) |=> ($stable(retired_cnt) && !res_valid && $stable(h_op0) && $stable(h_a0)));

  assert_two_slots_counted_R7: assert property (@(posedge clk) disable iff (rst)
    accept |=> (issued_ops == $past(issued_ops) + CNT_W'(2)));

  assert_stall_counted_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> (stall_cnt == $past(stall_cnt) + CNT_W'(1)));

  assert_countdown_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !done1) |=> (busy && wait_q == $past(wait_q) - LAT_W'(1)));

endmodule

// File: tb/vliw_lockstep_issue_tb_top.sv
`timescale 1ns/1ps
module vliw_lockstep_issue_tb_top;
  logic clk = 0, rst = 1, bundle_valid = 0;
  logic bundle_ready, res_valid;
  logic [31:0] slot0_op = 0, slot1_op = 0, slot0_a = 0, slot0_b = 0, slot1_a = 0, slot1_b = 0;
  logic [1:0]  lat_cfg = 0;
  logic [31:0] res0, res1;
  logic [15:0] retired_cnt, stall_cnt, issued_ops;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vliw_lockstep_issue dut_i (.*);

  function automatic logic [31:0] model(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    case (w[3:0])
      4'd1: return a + b;
      4'd2: return a - b;
      4'd3: return a & b;
      4'd4: return a | b;
      4'd5: return a ^ b;
      4'd6: return a + {4'b0, w[31:4]};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; bundle_valid = 0;
    @(negedge clk); rst = 0;
  endtask

  task automatic offer(input logic [31:0] o0, o1, a0, b0, a1, b1, input logic [1:0] l);
    slot0_op = o0; slot1_op = o1; slot0_a = a0; slot0_b = b0;
    slot1_a = a1; slot1_b = b1; lat_cfg = l; bundle_valid = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ready", bundle_ready, 1);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 counters", {retired_cnt, stall_cnt}, 0);
    chk("R1 issued", issued_ops, 0);
  endtask

  task automatic t_alu();
    do_reset();
    for (int k = 0; k < 9; k++) begin
      logic [31:0] w0, w1, a0, b0, a1, b1;
      w0 = {28'h0000123 + 28'(k), 4'(k)};
      w1 = {28'h0000050, 4'((k + 3) % 9)};
      a0 = 32'hF0F0_1234 + 32'(k); b0 = 32'h0FF0_0011;
      a1 = 32'h0000_00A5; b1 = 32'h1111_000F + 32'(k);
      offer(w0, w1, a0, b0, a1, b1, 2'd0);
      @(negedge clk);
      chk("R2 slot0 op", res0, model(w0, a0, b0));
      chk("R3 slot1 own operands", res1, model(w1, a1, b1));
    end
    bundle_valid = 0;
  endtask

  task automatic t_stream();
    do_reset();
    for (int k = 0; k < 3; k++) begin
      offer(32'd1, (k == 1) ? 32'd0 : 32'd2, 32'(k), 32'd10, 32'd50, 32'(k), (k == 1) ? 2'd3 : 2'd0);
      @(negedge clk);
      chk("R4 per-cycle retire", {31'd0, res_valid & bundle_ready}, 1);
    end
    bundle_valid = 0;
    chk("R4 three retired", retired_cnt, 3);
    chk("R4 no stall", stall_cnt, 0);
    chk("R7 nop counted", issued_ops, 6);
  endtask

  task automatic t_long(input logic [1:0] c);
    logic [31:0] e0, e1;
    do_reset();
    e0 = model(32'h3, 32'hFF00, 32'h0FF0);
    e1 = model(32'h1, 32'd7, 32'd9);
    offer(32'h3, 32'h1, 32'hFF00, 32'h0FF0, 32'd7, 32'd9, c);
    @(negedge clk);
    for (int i = 0; i < int'(c); i++) begin
      chk("R5 ready low", bundle_ready, 0);
      chk("R6 no early result", res_valid, 0);
      slot0_a = 32'hDEAD; slot1_a = 32'hBEEF; lat_cfg = 2'd3 - c;
      if (i == int'(c) - 1) bundle_valid = 0;
      @(negedge clk);
    end
    if (c == 0) bundle_valid = 0;
    chk("R5 result cycle", res_valid, 1);
    chk("R6 slot0 held", res0, e0);
    chk("R6 slot1 result", res1, e1);
    chk("R8 stall count", stall_cnt, 32'(c));
    chk("R10 latency sampled", retired_cnt, 1);
    @(negedge clk);
    chk("R6 no extra bundle", retired_cnt, 1);
  endtask

  task automatic t_nop_long();
    do_reset();
    offer(32'h5, 32'h0, 32'h3, 32'h6, 32'h1, 32'h1, 2'd3);
    @(negedge clk); bundle_valid = 0;
    chk("R7 nop immediate", {30'd0, res_valid, bundle_ready}, 3);
    chk("R7 nop result", res1, 0);
    chk("R7 issued", issued_ops, 2);
  endtask

  task automatic t_reset_mid();
    do_reset();
    offer(32'h1, 32'h1, 32'h1, 32'h1, 32'h1, 32'h1, 2'd3);
    @(negedge clk); bundle_valid = 0; rst = 1;
    @(negedge clk); rst = 0;
    for (int i = 0; i < 4; i++) begin
      chk("R9 dropped", res_valid, 0);
      @(negedge clk);
    end
    chk("R9 ready", bundle_ready, 1);
    chk("R9 none retired", retired_cnt, 0);
  endtask

  initial begin
    t_reset();
    t_alu();
    t_stream();
    for (int c = 0; c < 4; c++) t_long(2'(c));
    t_nop_long();
    t_reset_mid();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule